// File: doc/BRIEF.md
# Physical Address Region Checker

This block sits in a load/store pipeline one stage after address translation. It takes each physical access address and sorts it into one of three classes: peripheral (uncached), cacheable memory, or unmapped. An unmapped access produces a precise access fault. Loads and stores carry different cause codes. The block also raises an abort toward the data cache, so no line fill starts for an address that does not exist.

Each memory port (instruction fetch, data cache, peripheral) has its own map of one peripheral window and one cacheable window, because each port can reach a different interconnect. The request carries the index of the port it belongs to. The result is registered, one cycle behind the request, which keeps the comparators off the translation critical path. Two qualified enables go downstream. One lets a request enter the peripheral queue. The other allows store-to-load forwarding. A faulted access never asserts either of them.

Top module: `pa_region_checker`

## Requirements
- R1: While rst_ni is low, and on the first edge after it is released with vld_i low, every output is 0.
- R2: A valid request with any nonzero address bit at or above PA_W (bits 11:10 by default) gets cls_o = 0 and fault_o = 1, whatever the region maps say.
- R3: Otherwise the low PA_W bits are compared against the selected port's windows, each with an inclusive base and an exclusive limit base+size. A peripheral hit gives cls_o = 1. A cacheable hit gives cls_o = 2. The peripheral window wins where the two overlap. An address in neither window gives cls_o = 0 and fault_o = 1. A window may end exactly at 2^PA_W.
- R4: A faulted load reports cause_o = 5. A faulted store reports cause_o = 7. fault_addr_o carries the full request address. With no fault, cause_o and fault_addr_o are 0.
- R5: abort_o is 1 exactly when a valid result is faulted.
- R6: io_ok_o is 1 only for a valid, unfaulted result of class 1, so a faulted store is never handed to a peripheral queue.
- R7: fwd_ok_o is 1 only for a valid result of class 2, and never for class 1.
- R8: Every output follows its request by exactly one cycle, back to back. A cycle with vld_i = 0 gives all outputs 0 one cycle later.
- R9: port_i selects the map of that port. A port index of NUM_PORTS or above selects no windows, so every access on it is unmapped.
- R10: xlat_i has no effect on the classification. It is returned on xlat_o with the result of a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Request valid |
| port_i | input | PIDX_W | Memory port index |
| st_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | IN_AW | Physical address |
| xlat_i | input | 1 | Translation was active for this request |
| vld_o | output | 1 | Result valid |
| cls_o | output | 2 | 0 unmapped, 1 peripheral, 2 cacheable |
| fault_o | output | 1 | Access fault |
| cause_o | output | 5 | Fault cause (5 load, 7 store) |
| fault_addr_o | output | IN_AW | Faulting address |
| abort_o | output | 1 | Abort the matching data-cache request |
| io_ok_o | output | 1 | May enter the peripheral queue |
| fwd_ok_o | output | 1 | Store-to-load forwarding allowed |
| xlat_o | output | 1 | Registered translation flag |

## Verification
The hardest cases to reach are the edges of each window. These are the last address below a limit, a limit that equals 2^PA_W and would overflow a PA_W-bit sum, and the part where the peripheral window covers part of the cacheable one. The stimulus walks every address of the 12-bit space on every port index, including the one with no map, for both loads and stores, one request per cycle. It inserts periodic bubbles and toggles the translation flag, so every boundary is hit under back-to-back traffic. Expected results come from the window arithmetic in the bench.

// File: rtl/pa_region_pkg.sv
package pa_region_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_IO   = 2'd1,
    CLS_MEM  = 2'd2
  } cls_e;
  localparam logic [4:0] CAUSE_LD_FAULT = 5'd5;
  localparam logic [4:0] CAUSE_ST_FAULT = 5'd7;
endpackage

// File: rtl/pa_region_match.sv
module pa_region_match #(
  parameter int PA_W = 10
) (
  input  logic [PA_W-1:0] addr_i,
  input  logic [PA_W-1:0] base_i,
  input  logic [PA_W:0]   size_i,
  output logic            hit_o
);
  // one extra bit so a window may end at 2^PA_W
  logic [PA_W:0] lim;
  assign lim   = {1'b0, base_i} + size_i;
  assign hit_o = ({1'b0, addr_i} >= {1'b0, base_i}) && ({1'b0, addr_i} < lim);
endmodule

// File: rtl/pa_region_map.sv
module pa_region_map #(
  parameter int PA_W      = 10,
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = 2,
  parameter logic [NUM_PORTS-1:0][PA_W-1:0] IO_BASE  = '0,
  parameter logic [NUM_PORTS-1:0][PA_W:0]   IO_SIZE  = '0,
  parameter logic [NUM_PORTS-1:0][PA_W-1:0] MEM_BASE = '0,
  parameter logic [NUM_PORTS-1:0][PA_W:0]   MEM_SIZE = '0
) (
  input  logic [PIDX_W-1:0] port_i,
  input  logic [PA_W-1:0]   addr_i,
  output logic              io_hit_o,
  output logic              mem_hit_o
);
  localparam int NSEL = 2 ** PIDX_W;

  logic [NSEL-1:0] io_hits;
  logic [NSEL-1:0] mem_hits;

  for (genvar g = 0; g < NSEL; g++) begin : g_port
    if (g < NUM_PORTS) begin : g_map
      pa_region_match #(.PA_W(PA_W)) u_io (
        .addr_i(addr_i), .base_i(IO_BASE[g]), .size_i(IO_SIZE[g]), .hit_o(io_hits[g])
      );
      pa_region_match #(.PA_W(PA_W)) u_mem (
        .addr_i(addr_i), .base_i(MEM_BASE[g]), .size_i(MEM_SIZE[g]), .hit_o(mem_hits[g])
      );
    end else begin : g_none
      assign io_hits[g]  = 1'b0;
      assign mem_hits[g] = 1'b0;
    end
  end

  assign io_hit_o  = io_hits[port_i];
  assign mem_hit_o = mem_hits[port_i];
endmodule

// File: rtl/pa_region_checker.sv
module pa_region_checker
  import pa_region_pkg::*;
#(
  parameter int IN_AW     = 12,
  parameter int PA_W      = 10,
  parameter int NUM_PORTS = 3,
  parameter int PIDX_W    = (NUM_PORTS > 2) ? $clog2(NUM_PORTS) : 1,
  parameter logic [NUM_PORTS-1:0][PA_W-1:0] IO_BASE  = {10'h300, 10'h040, 10'h000},
  parameter logic [NUM_PORTS-1:0][PA_W:0]   IO_SIZE  = {11'h100, 11'h040, 11'h040},
  parameter logic [NUM_PORTS-1:0][PA_W-1:0] MEM_BASE = {10'h380, 10'h200, 10'h100},
  parameter logic [NUM_PORTS-1:0][PA_W:0]   MEM_SIZE = {11'h080, 11'h180, 11'h100}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [PIDX_W-1:0] port_i,
  input  logic              st_i,
  input  logic [IN_AW-1:0]  addr_i,
  input  logic              xlat_i,
  output logic              vld_o,
  output logic [1:0]        cls_o,
  output logic              fault_o,
  output logic [4:0]        cause_o,
  output logic [IN_AW-1:0]  fault_addr_o,
  output logic              abort_o,
  output logic              io_ok_o,
  output logic              fwd_ok_o,
  output logic              xlat_o
);
  logic io_hit, mem_hit, hi_bad;
  cls_e cls_n;
  logic fault_n;

  pa_region_map #(
    .PA_W(PA_W), .NUM_PORTS(NUM_PORTS), .PIDX_W(PIDX_W),
    .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE), .MEM_BASE(MEM_BASE), .MEM_SIZE(MEM_SIZE)
  ) u_map (
    .port_i(port_i), .addr_i(addr_i[PA_W-1:0]),
    .io_hit_o(io_hit), .mem_hit_o(mem_hit)
  );

  assign hi_bad = |addr_i[IN_AW-1:PA_W];

  always_comb begin
    if (hi_bad)       cls_n = CLS_NONE;
    else if (io_hit)  cls_n = CLS_IO;   // peripheral wins on overlap
    else if (mem_hit) cls_n = CLS_MEM;
    else              cls_n = CLS_NONE;
    fault_n = (cls_n == CLS_NONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0; cls_o <= '0; fault_o <= 1'b0; cause_o <= '0;
      fault_addr_o <= '0; abort_o <= 1'b0; io_ok_o <= 1'b0;
      fwd_ok_o <= 1'b0; xlat_o <= 1'b0;
    end else begin
      vld_o        <= vld_i;
      cls_o        <= vld_i ? cls_n : CLS_NONE;
      fault_o      <= vld_i && fault_n;
      cause_o      <= (vld_i && fault_n) ? (st_i ? CAUSE_ST_FAULT : CAUSE_LD_FAULT) : 5'd0;
      fault_addr_o <= (vld_i && fault_n) ? addr_i : '0;
      abort_o      <= vld_i && fault_n;
      io_ok_o      <= vld_i && (cls_n == CLS_IO);
      fwd_ok_o     <= vld_i && (cls_n == CLS_MEM);
      xlat_o       <= vld_i && xlat_i;
    end
  end

  a_r8_vld_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r8_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o && !fault_o && !io_ok_o && !fwd_ok_o && cls_o == 2'd0);
  a_r2_high_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && hi_bad) |=> fault_o && cls_o == 2'd0);
  a_r4_store_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && st_i && !io_hit && !mem_hit) |=> cause_o == 5'd7);
  a_r5_abort_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o == (vld_o && fault_o));
  a_r6_io_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ok_o |-> !fault_o && cls_o == 2'd1);
  a_r7_fwd_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_ok_o |-> cls_o == 2'd2 && !io_ok_o);
  a_r3_peri_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !hi_bad && io_hit) |=> cls_o == 2'd1);
endmodule

// File: tb/pa_region_checker_tb.sv
module pa_region_checker_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, st = 1'b0, xl = 1'b0;
  logic [1:0] port = '0;
  logic [11:0] addr = '0;
  logic vld_o, fault_o, abort_o, io_ok_o, fwd_ok_o, xlat_o;
  logic [1:0] cls_o;
  logic [4:0] cause_o;
  logic [11:0] fault_addr_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pa_region_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vld_i(vld), .port_i(port), .st_i(st),
    .addr_i(addr), .xlat_i(xl), .vld_o(vld_o), .cls_o(cls_o), .fault_o(fault_o),
    .cause_o(cause_o), .fault_addr_o(fault_addr_o), .abort_o(abort_o),
    .io_ok_o(io_ok_o), .fwd_ok_o(fwd_ok_o), .xlat_o(xlat_o)
  );

  int iob[3] = '{'h000, 'h040, 'h300};
  int ios[3] = '{'h040, 'h040, 'h100};
  int mb[3]  = '{'h100, 'h200, 'h380};
  int ms[3]  = '{'h100, 'h180, 'h080};

  // expected result of the request in flight
  logic e_vld, e_fault, e_abort, e_io, e_fwd, e_xl;
  logic [1:0] e_cls;
  logic [4:0] e_cause;
  logic [11:0] e_fa;
  string e_tag;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out();
    chk("R8 vld", vld_o, e_vld);
    chk(e_tag, cls_o, e_cls);
    chk(e_tag, fault_o, e_fault);
    chk("R4 cause", cause_o, e_cause);
    chk("R4 fault_addr", fault_addr_o, e_fa);
    chk("R5 abort", abort_o, e_abort);
    chk("R6 io_ok", io_ok_o, e_io);
    chk("R7 fwd_ok", fwd_ok_o, e_fwd);
    chk("R10 xlat", xlat_o, e_xl);
  endtask

  task automatic model(logic v, int p, int a, logic s, logic x);
    int pa = a & 'h3ff;
    logic hi = (a >> 10) != 0;
    logic io = 0, mem = 0;
    if (p < 3) begin
      io  = pa >= iob[p] && pa < iob[p] + ios[p];
      mem = pa >= mb[p] && pa < mb[p] + ms[p];
    end
    e_tag = hi ? "R2 high" : (p >= 3 ? "R9 noport" : "R3 class");
    e_vld = v;
    e_cls = !v ? 2'd0 : hi ? 2'd0 : io ? 2'd1 : mem ? 2'd2 : 2'd0;
    e_fault = v && e_cls == 2'd0;
    e_cause = e_fault ? (s ? 5'd7 : 5'd5) : 5'd0;
    e_fa = e_fault ? 12'(a) : 12'd0;
    e_abort = e_fault;
    e_io = e_cls == 2'd1;
    e_fwd = e_cls == 2'd2;
    e_xl = v && x;
  endtask

  task automatic step(logic v, int p, int a, logic s, logic x);
    @(negedge clk);
    check_out();
    model(v, p, a, s, x);
    vld = v; port = 2'(p); addr = 12'(a); st = s; xl = x;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model(1'b0, 0, 0, 1'b0, 1'b0);
    e_tag = "R1 reset";
    repeat (3) @(negedge clk);
    check_out();                           // R1 under reset
    vld = 1'b1; addr = 12'h123;            // must be ignored while in reset
    @(negedge clk);
    check_out();
    vld = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    e_tag = "R1 reset";
    check_out();                           // R1 after release, idle input
    model(1'b0, 0, 0, 1'b0, 1'b0);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 4096; a++) begin
          if ((a % 7) == 3) step(1'b0, p, a ^ 'h2aa, s[0], 1'b1);   // R8 bubble
          step(1'b1, p, a, s[0], 1'(a[0] ^ p[0] ^ s[0]));
        end
    step(1'b0, 0, 0, 1'b0, 1'b0);
    step(1'b0, 0, 0, 1'b0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule